// File: doc/BRIEF.md
# Tagged Conversion Result Queue

This block buffers results from a multi-channel converter until a register-read interface collects them. Each write carries a 12-bit result and the code of the channel it came from. The block packs these into a 16-bit word, with the channel code in the upper four bits and the result below it, and keeps up to fifteen such words in arrival order. A read pops the oldest word into a registered output.

The queue always keeps the newest results. A write into a full queue with no read in the same cycle discards the oldest word. The block then sets a sticky overflow flag. A read from an empty queue returns a reserved underflow word and sets a sticky underflow flag. A one-cycle clear pulse, issued when the flag register is read, drops both flags. A synchronous flush empties the queue and clears the flags.

Top module: `tagged_result_fifo`

## Requirements
- R1: After reset, `level` is 0, both flags are 0 and `rd_word` is 16'h0000.
- R2: A popped word has the channel code in bits [15:12] and the result in bits [11:0]. The channel codes are 0 die temperature, 1 remote diode 1, 2 remote diode 2, 3 amplifier output 1, 4 amplifier output 2, 5 auxiliary input 1 and 6 auxiliary input 2. The word appears on `rd_word` after the clock edge that samples `rd_en`, and it holds until the next read.
- R3: Words leave in the order they were written. The queue holds up to 15 of them, and `level` gives the number held.
- R4: A write while 15 words are held and `rd_en` is low discards the oldest word, stores the new one and leaves `level` at 15.
- R5: Losing a word to R4 sets `ovf_flag`. The flag then stays set until it is cleared by R8 or R9.
- R6: A read while `level` is 0 returns 16'hF000 (reserved tag 4'hF, data 0) and sets the sticky `udf_flag`. `level` stays 0 unless a write is stored in the same cycle.
- R7: A read and a write in the same cycle while full return the oldest word and store the new one. `level` stays at 15 and `ovf_flag` is not set.
- R8: A `flag_clr` pulse clears both flags. An overflow or underflow event in the same cycle as the pulse leaves its flag set.
- R9: `flush` sets `level` to 0 and clears both flags. It takes priority over a write, a read and any flag event in the same cycle.
- R10: A read and a write in the same cycle while not full and not empty leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty and flag clear |
| wr_en | input | 1 | Store a result this cycle |
| wr_chan | input | 3 | Channel code of the result |
| wr_data | input | 12 | Conversion result |
| rd_en | input | 1 | Pop one word this cycle |
| flag_clr | input | 1 | One-cycle clear pulse for both flags |
| rd_word | output | 16 | Last popped word (tag and data) |
| level | output | 4 | Number of words held |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
Every result is due one clock edge after its stimulus. This covers the popped word on `rd_word`, the new `level` and the updated flags, because each comes straight from a register loaded at that edge. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge against a queue model that applies R3 to R10 in the same cycle. Sweeps over fill depths from 0 to 18 cross the full and empty boundaries. A pseudo-random mix of simultaneous operations covers the same-cycle cases.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
   localparam int TAG_W = 4;

   typedef enum logic [TAG_W-1:0] {
      TAG_DIE   = 4'd0,
      TAG_RD1   = 4'd1,
      TAG_RD2   = 4'd2,
      TAG_AMP1  = 4'd3,
      TAG_AMP2  = 4'd4,
      TAG_AUX1  = 4'd5,
      TAG_AUX2  = 4'd6,
      TAG_EMPTY = 4'hF
   } tag_e;
endpackage

// File: rtl/tfifo_ptr_ctrl.sv
module tfifo_ptr_ctrl #(
   parameter int DEPTH = 15,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [PW-1:0] head,
   output logic [PW-1:0] tail,
   output logic [CW-1:0] level,
   output logic          do_write,
   output logic          do_pop,
   output logic          drop_evt,
   output logic          udf_evt
);
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic          empty, full, head_adv;
   logic [PW-1:0] head_inc, tail_inc;

   generate
      if (POW2) begin : g_wrap_free
         assign head_inc = head + 1'b1;
         assign tail_inc = tail + 1'b1;
      end else begin : g_wrap_cmp
         assign head_inc = (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
         assign tail_inc = (tail == PW'(DEPTH - 1)) ? '0 : tail + 1'b1;
      end
   endgenerate

   always_comb begin
      empty    = (level == '0);
      full     = (level == CW'(DEPTH));
      do_write = wr_en & ~flush;
      do_pop   = rd_en & ~empty & ~flush;
      udf_evt  = rd_en & empty & ~flush;
      drop_evt = do_write & full & ~rd_en;
      head_adv = do_pop | drop_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         level <= '0;
      end else if (flush) begin
         head  <= '0;
         tail  <= '0;
         level <= '0;
      end else begin
         if (head_adv) head <= head_inc;
         if (do_write) tail <= tail_inc;
         if (do_write && !do_pop && !drop_evt) level <= level + 1'b1;
         else if (do_pop && !do_write)         level <= level - 1'b1;
      end
   end
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
   parameter int DEPTH  = 15,
   parameter int WORD_W = 16,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tfifo_flags.sv
module tfifo_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic clr,
   input  logic ovf_evt,
   input  logic udf_evt,
   output logic ovf,
   output logic udf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
         udf <= 1'b0;
      end else if (flush) begin
         ovf <= 1'b0;
         udf <= 1'b0;
      end else begin
         ovf <= (ovf & ~clr) | ovf_evt;
         udf <= (udf & ~clr) | udf_evt;
      end
   end
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo
   import tfifo_pkg::*;
#(
   parameter int DEPTH  = 15,
   parameter int DATA_W = 12,
   parameter int CH_W   = 3,
   localparam int WORD_W = TAG_W + DATA_W,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_chan,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              flag_clr,
   output logic [WORD_W-1:0] rd_word,
   output logic [CW-1:0]     level,
   output logic              ovf_flag,
   output logic              udf_flag
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2)     $error("tagged_result_fifo: DEPTH must be at least 2");
   if (CH_W > TAG_W)  $error("tagged_result_fifo: channel code wider than tag");
   if (DATA_W < 1)    $error("tagged_result_fifo: DATA_W must be positive");

   logic [PW-1:0]     head, tail;
   logic              do_write, do_pop, drop_evt, udf_evt;
   logic [WORD_W-1:0] wr_word, head_word;

   assign wr_word = {TAG_W'(wr_chan), wr_data};

   tfifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .head     (head),
      .tail     (tail),
      .level    (level),
      .do_write (do_write),
      .do_pop   (do_pop),
      .drop_evt (drop_evt),
      .udf_evt  (udf_evt)
   );

   tfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk   (clk),
      .we    (do_write),
      .waddr (tail),
      .wdata (wr_word),
      .raddr (head),
      .rdata (head_word)
   );

   tfifo_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .clr     (flag_clr),
      .ovf_evt (drop_evt),
      .udf_evt (udf_evt),
      .ovf     (ovf_flag),
      .udf     (udf_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_word <= '0;
      else if (do_pop)  rd_word <= head_word;
      else if (udf_evt) rd_word <= {TAG_EMPTY, {DATA_W{1'b0}}};
   end
endmodule

// File: rtl/tagged_result_fifo_chk.sv
module tagged_result_fifo_chk #(
   parameter int DEPTH  = 15,
   parameter int WORD_W = 16,
   parameter int CW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wr_en,
   input logic              rd_en,
   input logic              flag_clr,
   input logic [WORD_W-1:0] rd_word,
   input logic [CW-1:0]     level,
   input logic              ovf_flag,
   input logic              udf_flag
);
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_en && !rd_en && level == CW'(DEPTH)) |=> (level == CW'(DEPTH)));

   p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_en && !rd_en && level == CW'(DEPTH)) |=> ovf_flag);

   p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr && !flush) |=> ovf_flag);

   p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && rd_en && level == '0) |=> (udf_flag && rd_word == {4'hF, {(WORD_W-4){1'b0}}}));

   p_full_rdwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_en && rd_en && level == CW'(DEPTH) && !ovf_flag)
      |=> (level == CW'(DEPTH) && !ovf_flag));

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0 && !ovf_flag && !udf_flag));

   p_rdwr_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_en && rd_en && level != '0) |=> $stable(level));
endmodule

bind tagged_result_fifo tagged_result_fifo_chk #(
   .DEPTH(DEPTH), .WORD_W(WORD_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
   .flag_clr(flag_clr), .rd_word(rd_word), .level(level),
   .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/tagged_result_fifo_test.sv
module tagged_result_fifo_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
   logic [2:0]  wr_chan = '0;
   logic [11:0] wr_data = '0;
   logic [15:0] rd_word;
   logic [3:0]  level;
   logic        ovf_flag, udf_flag;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [15:0] mq[$];
   logic        e_ovf = 1'b0, e_udf = 1'b0;
   logic [15:0] e_word = 16'h0000;

   always #(CLK_PERIOD/2) clk = ~clk;

   tagged_result_fifo uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
      .wr_chan(wr_chan), .wr_data(wr_data), .rd_en(rd_en),
      .flag_clr(flag_clr), .rd_word(rd_word), .level(level),
      .ovf_flag(ovf_flag), .udf_flag(udf_flag)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // one cycle: drive at falling edge, model the same cycle, compare one edge later
   task automatic step(input bit wr, input int ch, input int d, input bit rd,
                       input bit clr, input bit fl, input string req);
      logic ev_ovf, ev_udf;
      wr_en = wr; wr_chan = 3'(ch); wr_data = 12'(d);
      rd_en = rd; flag_clr = clr; flush = fl;
      ev_ovf = 1'b0; ev_udf = 1'b0;
      if (fl) begin
         mq.delete();
         e_ovf = 1'b0; e_udf = 1'b0;
      end else begin
         if (rd) begin
            if (mq.size() == 0) begin
               e_word = 16'hF000; ev_udf = 1'b1;
            end else e_word = mq.pop_front();
         end
         if (wr) begin
            if (mq.size() == DEPTH) begin
               void'(mq.pop_front()); ev_ovf = 1'b1;
            end
            mq.push_back({4'(ch), 12'(d)});
         end
         if (clr) begin e_ovf = 1'b0; e_udf = 1'b0; end
         e_ovf |= ev_ovf; e_udf |= ev_udf;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; flag_clr = 1'b0; flush = 1'b0;
      if (rd && !fl) check(req, "rd_word R2", int'(rd_word), int'(e_word));
      check(req, "level R3", int'(level), mq.size());
      check(req, "ovf_flag R5", int'(ovf_flag), int'(e_ovf));
      check(req, "udf_flag R6", int'(udf_flag), int'(e_udf));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "level", int'(level), 0);
      check("R1", "ovf", int'(ovf_flag), 0);
      check("R1", "udf", int'(udf_flag), 0);
      check("R1", "rd_word", int'(rd_word), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5 R6 sweep over fill depths across both boundaries
      for (int n = 0; n <= 18; n++) begin
         step(0, 0, 0, 0, 0, 1, "R9");
         for (int i = 0; i < n; i++)
            step(1, (n + i) % 7, (n * 37 + i * 113) & 12'hFFF, 0, 0, 0, "R4");
         check("R4", "level after fill", int'(level), (n > DEPTH) ? DEPTH : n);
         check("R5", "ovf after fill", int'(ovf_flag), (n > DEPTH) ? 1 : 0);
         for (int i = 0; i <= ((n > DEPTH) ? DEPTH : n); i++)
            step(0, 0, 0, 1, 0, 0, "R3");
         check("R6", "underflow word", int'(rd_word), 16'hF000);
      end

      // R7: full with simultaneous read and write
      step(0, 0, 0, 0, 0, 1, "R9");
      for (int i = 0; i < DEPTH; i++) step(1, i % 7, i + 1, 0, 0, 0, "R7");
      step(1, 6, 12'hABC, 1, 0, 0, "R7");
      check("R7", "ovf stays clear", int'(ovf_flag), 0);
      check("R7", "level stays full", int'(level), DEPTH);
      check("R7", "oldest returned", int'(rd_word), 16'h0001);

      // R9: flush wins over write and read
      step(1, 2, 12'h123, 1, 0, 1, "R9");
      check("R9", "level after flush", int'(level), 0);

      // R8: clear with simultaneous underflow keeps the flag
      step(0, 0, 0, 1, 0, 0, "R8");
      step(0, 0, 0, 1, 1, 0, "R8");
      check("R8", "udf set wins over clear", int'(udf_flag), 1);
      step(0, 0, 0, 0, 1, 0, "R8");
      check("R8", "udf cleared", int'(udf_flag), 0);

      // R6: empty read with a write in the same cycle stores the write
      step(1, 3, 12'h5A5, 1, 0, 0, "R6");
      check("R6", "level after empty rd+wr", int'(level), 1);

      // R10: simultaneous read and write mid-level
      for (int i = 0; i < 4; i++) step(1, 5, i * 9, 0, 0, 0, "R10");
      step(1, 1, 12'h777, 1, 0, 0, "R10");
      check("R10", "level unchanged", int'(level), 5);

      // pseudo-random mix of all operations against the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[1], int'(lfsr[4:2]) % 7, int'(lfsr[15:4]),
              lfsr[5] & lfsr[6], lfsr[7] & lfsr[8] & lfsr[9],
              (lfsr[11:9] == 3'b111) && lfsr[3], "R3");
      end

      done = 1'b1;
      finish_run();
   end
endmodule